// File: doc/BRIEF.md
# SD host preset value selector

This block holds eight 16-bit preset words that configure the card clock and driver path of an SD/eMMC host. Software reads and writes them through a simple register port with a byte enable for each byte. Each word carries a 2-bit driver strength code, a one-bit clock generator select and a 10-bit clock divider code.

Three control inputs set the bus speed mode: the 1.8V signalling enable, the high-speed enable and a 3-bit UHS mode code. The block decodes that mode into a preset index. When preset mode is on, the registered effective driver, generator and divider outputs come from the selected preset. When it is off, they come from the software-programmed fields. An init input forces the initialization preset (index 0), which the speed decode never picks on its own.

If preset mode is on and the UHS code is reserved, the block falls back to the software fields. It also sets a sticky flag, which software can read and clear at a status address.

Top module: `sd_preset_selector`

## Requirements
- R1: After a synchronous active-low reset, every preset reads 0, the effective outputs are 0 and the reserved flag is 0.
- R2: Preset i sits at byte address 0x60 + 2*i. be[0] writes bits 7:0 (divider low bits). be[1] writes bits 15:14 (driver), bit 10 (generator select) and bits 9:8 (divider high bits). Bits 13:11 always read 0. Reads are combinational.
- R3: With preset_en = 0, the effective outputs equal the software fields sampled at the previous clock edge.
- R4: With preset_en = 1, init_active = 0 and sig_1v8_en = 0, hs_en = 0 selects preset 1 and hs_en = 1 selects preset 2. The UHS code has no effect.
- R5: With preset_en = 1, init_active = 0 and sig_1v8_en = 1, UHS code 0, 1, 2, 3, 4 selects preset 3, 4, 5, 6, 7. hs_en has no effect.
- R6: With preset_en = 1 and init_active = 1, preset 0 drives the outputs whatever the speed mode.
- R7: With preset_en = 1, init_active = 0, sig_1v8_en = 1 and UHS code 5 to 7, the outputs follow the software fields and the reserved flag becomes 1. The flag reads as bit 0 at address 0x70.
- R8: The reserved flag stays set until a write to 0x70 with be[0] = 1 and wdata[0] = 1 clears it. A set condition in the same cycle wins over the clear.
- R9: The effective outputs are registered. A mode change shows one edge after it is applied. A write to the selected preset shows one edge after the write edge.
- R10: A write to an address outside the map (including odd addresses) changes no preset, and such reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_be | input | 2 | Byte enables for the write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data |
| sig_1v8_en | input | 1 | 1.8V signalling enable |
| hs_en | input | 1 | High-speed enable |
| uhs_mode | input | 3 | UHS mode code |
| preset_en | input | 1 | Preset mode enable |
| init_active | input | 1 | Force the initialization preset |
| sw_drv_str | input | 2 | Software driver strength |
| sw_clk_gen_sel | input | 1 | Software clock generator select |
| sw_clk_div | input | 10 | Software clock divider code |
| eff_drv_str | output | 2 | Effective driver strength |
| eff_clk_gen_sel | output | 1 | Effective clock generator select |
| eff_clk_div | output | 10 | Effective clock divider code |
| rsvd_flag | output | 1 | Sticky reserved-mode flag |

## Verification
A register write to the preset that is currently selected can land in the same cycle as the output register samples that preset. The bench issues such a write while the mode is held. It then checks that the output keeps the old value one edge after the write and shows the new value one edge later. A second collision is a status clear arriving in the same cycle as a reserved-mode set. The bench provokes it by entering a reserved code together with the clear write, and it judges the result by reading the flag back as still set.

// File: rtl/sdp_pkg.sv
// Package: shared preset word type, field positions and mode index constants.
// Assumes the register word is 16 bits with fixed field positions.
package sdp_pkg;
    localparam int DRV_W      = 2;
    localparam int DIV_W      = 10;
    localparam int WORD_W     = 16;
    localparam int DRV_LSB    = 14;
    localparam int CGS_BIT    = 10;
    localparam int UHS_LAST   = 4;
    localparam int IDX_INIT   = 0;
    localparam int IDX_DS     = 1;
    localparam int IDX_HS     = 2;
    localparam int IDX_UHS0   = 3;

    typedef struct packed {
        logic [DRV_W-1:0] drv;
        logic             cgs;
        logic [DIV_W-1:0] div;
    } preset_t;

    // Place a preset into its 16-bit register image; unused bits read zero.
    function automatic logic [WORD_W-1:0] to_word(input preset_t p);
        logic [WORD_W-1:0] w;
        w = '0;
        w[DRV_LSB +: DRV_W] = p.drv;
        w[CGS_BIT]          = p.cgs;
        w[DIV_W-1:0]        = p.div;
        return w;
    endfunction
endpackage

// File: rtl/sdp_mode_decode.sv
// Module: sdp_mode_decode
// Turns the speed-mode control inputs into a preset index and flags
// reserved UHS codes. Purely combinational; assumes a 3-bit UHS code.
module sdp_mode_decode #(
    parameter int NUM_PRESETS = 8,
    parameter int UHS_W       = 3,
    localparam int IDX_W      = $clog2(NUM_PRESETS)
) (
    input  logic             sig_1v8_en,
    input  logic             hs_en,
    input  logic [UHS_W-1:0] uhs_mode,
    output logic [IDX_W-1:0] mode_idx,
    output logic             mode_rsvd
);
    import sdp_pkg::*;

    // Map the speed mode to its preset slot.
    always_comb begin
        mode_idx  = IDX_W'(IDX_DS);
        mode_rsvd = 1'b0;
        if (!sig_1v8_en) begin
            mode_idx = hs_en ? IDX_W'(IDX_HS) : IDX_W'(IDX_DS);
        end else if (int'(uhs_mode) <= UHS_LAST) begin
            mode_idx = IDX_W'(IDX_UHS0) + IDX_W'(uhs_mode);
        end else begin
            mode_rsvd = 1'b1;
        end
    end
endmodule

// File: rtl/sdp_preset_bank.sv
// Module: sdp_preset_bank
// Holds the preset words, decodes their byte addresses and serves reads.
// Assumes presets sit at BASE_ADDR + 2*i; odd addresses never hit.
module sdp_preset_bank #(
    parameter int NUM_PRESETS = 8,
    parameter int ADDR_W      = 8,
    parameter int BASE_ADDR   = 'h60
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [1:0]            be,
    input  logic [15:0]           wdata,
    output logic [15:0]           rdata,
    output sdp_pkg::preset_t      bank_q [NUM_PRESETS]
);
    import sdp_pkg::*;

    logic [NUM_PRESETS-1:0] hit;
    logic                   unused_bits;

    assign unused_bits = ^wdata[13:11];

    for (genvar g = 0; g < NUM_PRESETS; g++) begin : g_slot
        assign hit[g] = (addr == ADDR_W'(BASE_ADDR + 2 * g));

        // Byte-enabled update of one preset word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[g] <= '0;
            end else if (wr_en && hit[g]) begin
                if (be[0]) begin
                    bank_q[g].div[7:0] <= wdata[7:0];
                end
                if (be[1]) begin
                    bank_q[g].drv      <= wdata[DRV_LSB +: DRV_W];
                    bank_q[g].cgs      <= wdata[CGS_BIT];
                    bank_q[g].div[9:8] <= wdata[9:8];
                end
            end
        end
    end

    // Return the addressed word, zero when nothing hits.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_PRESETS; i++) begin
            if (hit[i]) rdata = to_word(bank_q[i]);
        end
    end
endmodule

// File: rtl/sdp_eff_reg.sv
// Module: sdp_eff_reg
// Chooses between software fields and a preset and registers the result.
// Assumes index 0 is the initialization preset.
module sdp_eff_reg #(
    parameter int NUM_PRESETS = 8,
    localparam int IDX_W      = $clog2(NUM_PRESETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             preset_en,
    input  logic             init_active,
    input  logic [IDX_W-1:0] mode_idx,
    input  logic             mode_rsvd,
    input  sdp_pkg::preset_t sw_fields,
    input  sdp_pkg::preset_t bank_q [NUM_PRESETS],
    output sdp_pkg::preset_t eff_q
);
    import sdp_pkg::*;

    preset_t eff_d;

    // Source selection: init preset, speed preset or software fields.
    always_comb begin
        eff_d = sw_fields;
        if (preset_en) begin
            if (init_active)     eff_d = bank_q[IDX_INIT];
            else if (!mode_rsvd) eff_d = bank_q[mode_idx];
        end
    end

    // Output register so the fields change only on a clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) eff_q <= '0;
        else        eff_q <= eff_d;
    end
endmodule

// File: rtl/sdp_rsvd_flag.sv
// Module: sdp_rsvd_flag
// Sticky reserved-mode flag with a write-one-to-clear status address.
// Assumes a set request wins over a clear in the same cycle.
module sdp_rsvd_flag #(
    parameter int ADDR_W      = 8,
    parameter int STATUS_ADDR = 'h70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_req,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              be0,
    input  logic              wbit0,
    output logic              flag_q,
    output logic              rd_hit
);
    logic clr_req;

    assign rd_hit  = (addr == ADDR_W'(STATUS_ADDR));
    assign clr_req = wr_en && rd_hit && be0 && wbit0;

    // Set has priority; clear only when no new reserved use is seen.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (set_req) flag_q <= 1'b1;
        else if (clr_req) flag_q <= 1'b0;
    end
endmodule

// File: rtl/sd_preset_selector.sv
// Module: sd_preset_selector (top)
// Preset bank, speed-mode decode, registered effective outputs and the
// reserved-mode status. Assumes software loads preset 0 before asserting
// init_active with preset_en.
module sd_preset_selector #(
    parameter int NUM_PRESETS = 8,
    parameter int ADDR_W      = 8,
    parameter int BASE_ADDR   = 'h60,
    parameter int STATUS_ADDR = 'h70,
    parameter int UHS_W       = 3,
    localparam int IDX_W      = $clog2(NUM_PRESETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [1:0]        reg_be,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              sig_1v8_en,
    input  logic              hs_en,
    input  logic [UHS_W-1:0]  uhs_mode,
    input  logic              preset_en,
    input  logic              init_active,
    input  logic [1:0]        sw_drv_str,
    input  logic              sw_clk_gen_sel,
    input  logic [9:0]        sw_clk_div,
    output logic [1:0]        eff_drv_str,
    output logic              eff_clk_gen_sel,
    output logic [9:0]        eff_clk_div,
    output logic              rsvd_flag
);
    import sdp_pkg::*;

    preset_t          bank_q [NUM_PRESETS];
    preset_t          sw_fields;
    preset_t          eff_q;
    logic [IDX_W-1:0] mode_idx;
    logic             mode_rsvd;
    logic [15:0]      bank_rdata;
    logic             stat_hit;
    logic             set_req;

    assign sw_fields = '{drv: sw_drv_str, cgs: sw_clk_gen_sel, div: sw_clk_div};
    assign set_req   = preset_en && !init_active && mode_rsvd;

    sdp_mode_decode #(.NUM_PRESETS(NUM_PRESETS), .UHS_W(UHS_W)) u_decode (
        .sig_1v8_en (sig_1v8_en),
        .hs_en      (hs_en),
        .uhs_mode   (uhs_mode),
        .mode_idx   (mode_idx),
        .mode_rsvd  (mode_rsvd)
    );

    sdp_preset_bank #(
        .NUM_PRESETS(NUM_PRESETS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .addr   (reg_addr),
        .be     (reg_be),
        .wdata  (reg_wdata),
        .rdata  (bank_rdata),
        .bank_q (bank_q)
    );

    sdp_eff_reg #(.NUM_PRESETS(NUM_PRESETS)) u_eff (
        .clk         (clk),
        .rst_n       (rst_n),
        .preset_en   (preset_en),
        .init_active (init_active),
        .mode_idx    (mode_idx),
        .mode_rsvd   (mode_rsvd),
        .sw_fields   (sw_fields),
        .bank_q      (bank_q),
        .eff_q       (eff_q)
    );

    sdp_rsvd_flag #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)) u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_req),
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .be0     (reg_be[0]),
        .wbit0   (reg_wdata[0]),
        .flag_q  (rsvd_flag),
        .rd_hit  (stat_hit)
    );

    // Merge preset read data with the status word.
    always_comb begin
        reg_rdata = bank_rdata;
        if (stat_hit) reg_rdata = {15'd0, rsvd_flag};
    end

    assign eff_drv_str     = eff_q.drv;
    assign eff_clk_gen_sel = eff_q.cgs;
    assign eff_clk_div     = eff_q.div;
endmodule

// File: rtl/sdp_checker.sv
// Module: sdp_checker
// Temporal checks on the preset selector, bound into the top module.
module sdp_checker #(
    parameter int NUM_PRESETS = 8,
    parameter int ADDR_W      = 8,
    parameter int STATUS_ADDR = 'h70,
    parameter int UHS_W       = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              be0,
    input logic              wbit0,
    input logic [15:0]       reg_rdata,
    input logic              sig_1v8_en,
    input logic              hs_en,
    input logic [UHS_W-1:0]  uhs_mode,
    input logic              preset_en,
    input logic              init_active,
    input logic [12:0]       sw_word,
    input logic [12:0]       eff_word,
    input logic              rsvd_flag,
    input sdp_pkg::preset_t  bank_q [NUM_PRESETS]
);
    logic clr_wr;
    logic rsvd_use;
    logic spd_ok;

    assign clr_wr   = reg_wr_en && (reg_addr == ADDR_W'(STATUS_ADDR)) && be0 && wbit0;
    assign rsvd_use = preset_en && !init_active && sig_1v8_en && (int'(uhs_mode) > 4);
    assign spd_ok   = rst_n && preset_en && !init_active;

    p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[13:11] == 3'b000);

    p_sw_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !preset_en |=> eff_word == $past(sw_word));

    p_default_speed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        spd_ok && !sig_1v8_en && !hs_en |=> eff_word == $past(bank_q[1]));

    p_high_speed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        spd_ok && !sig_1v8_en && hs_en |=> eff_word == $past(bank_q[2]));

    p_sdr12_r5: assert property (@(posedge clk) disable iff (!rst_n)
        spd_ok && sig_1v8_en && uhs_mode == 3'd0 |=> eff_word == $past(bank_q[3]));

    p_ddr50_r5: assert property (@(posedge clk) disable iff (!rst_n)
        spd_ok && sig_1v8_en && uhs_mode == 3'd4 |=> eff_word == $past(bank_q[7]));

    p_init_preset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        preset_en && init_active |=> eff_word == $past(bank_q[0]));

    p_rsvd_fallback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_use |=> eff_word == $past(sw_word));

    p_rsvd_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_use |=> rsvd_flag);

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_flag && !clr_wr |=> rsvd_flag);

    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr && !rsvd_use |=> !rsvd_flag);
endmodule

bind sd_preset_selector sdp_checker #(
    .NUM_PRESETS(NUM_PRESETS), .ADDR_W(ADDR_W),
    .STATUS_ADDR(STATUS_ADDR), .UHS_W(UHS_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_addr    (reg_addr),
    .be0         (reg_be[0]),
    .wbit0       (reg_wdata[0]),
    .reg_rdata   (reg_rdata),
    .sig_1v8_en  (sig_1v8_en),
    .hs_en       (hs_en),
    .uhs_mode    (uhs_mode),
    .preset_en   (preset_en),
    .init_active (init_active),
    .sw_word     ({sw_drv_str, sw_clk_gen_sel, sw_clk_div}),
    .eff_word    ({eff_drv_str, eff_clk_gen_sel, eff_clk_div}),
    .rsvd_flag   (rsvd_flag),
    .bank_q      (bank_q)
);

// File: tb/sd_preset_selector_bench.sv
module sd_preset_selector_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [12:0] SW_VAL = {2'b11, 1'b1, 10'h3A5};
    localparam logic [12:0] NEW_VAL = {2'b10, 1'b0, 10'h155};

    // {v18, hs, uhs[2:0], init, pen, 1'b0, expected index (8 = software)}
    localparam logic [11:0] VEC [12] = '{
        {1'b0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 4'd8},
        {1'b0, 1'b0, 3'd3, 1'b0, 1'b1, 1'b0, 4'd1},
        {1'b0, 1'b1, 3'd6, 1'b0, 1'b1, 1'b0, 4'd2},
        {1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 4'd3},
        {1'b1, 1'b1, 3'd1, 1'b0, 1'b1, 1'b0, 4'd4},
        {1'b1, 1'b0, 3'd2, 1'b0, 1'b1, 1'b0, 4'd5},
        {1'b1, 1'b1, 3'd3, 1'b0, 1'b1, 1'b0, 4'd6},
        {1'b1, 1'b0, 3'd4, 1'b0, 1'b1, 1'b0, 4'd7},
        {1'b1, 1'b0, 3'd3, 1'b1, 1'b1, 1'b0, 4'd0},
        {1'b1, 1'b1, 3'd6, 1'b1, 1'b1, 1'b0, 4'd0},
        {1'b1, 1'b0, 3'd5, 1'b0, 1'b1, 1'b0, 4'd8},
        {1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd8}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr_en = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [1:0] reg_be = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic sig_1v8_en = 1'b0, hs_en = 1'b0, preset_en = 1'b0, init_active = 1'b0;
    logic [2:0] uhs_mode = '0;
    logic [1:0] sw_drv_str = '0;
    logic sw_clk_gen_sel = 1'b0;
    logic [9:0] sw_clk_div = '0;
    logic [1:0] eff_drv_str;
    logic eff_clk_gen_sel;
    logic [9:0] eff_clk_div;
    logic rsvd_flag;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sd_preset_selector u_sd_preset_selector (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sig_1v8_en(sig_1v8_en), .hs_en(hs_en), .uhs_mode(uhs_mode),
        .preset_en(preset_en), .init_active(init_active),
        .sw_drv_str(sw_drv_str), .sw_clk_gen_sel(sw_clk_gen_sel),
        .sw_clk_div(sw_clk_div), .eff_drv_str(eff_drv_str),
        .eff_clk_gen_sel(eff_clk_gen_sel), .eff_clk_div(eff_clk_div),
        .rsvd_flag(rsvd_flag)
    );

    function automatic logic [12:0] pval(input int i);
        logic [1:0] d = 2'(i);
        logic c = i[2];
        logic [9:0] v = 10'(i * 37 + 5);
        return {d, c, v};
    endfunction

    function automatic logic [15:0] word_of(input logic [12:0] p);
        return {p[12:11], 3'b000, p[10], p[9:0]};
    endfunction

    function automatic logic [12:0] eff_now();
        return {eff_drv_str, eff_clk_gen_sel, eff_clk_div};
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [15:0] d, input logic [1:0] b);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_be = b; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_be = '0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_mode(input logic [11:0] v);
        sig_1v8_en = v[11]; hs_en = v[10]; uhs_mode = v[9:7];
        init_active = v[6]; preset_en = v[5];
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        logic [3:0] ex;
        logic [12:0] exp_v;
        string tag;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check(eff_now() == 13'd0, "R1 eff", 16'(eff_now()), 16'd0);
        reg_read(8'h70, rd);
        check(rd == 16'd0, "R1 flag", rd, 16'd0);
        for (int i = 0; i < 8; i++) begin
            reg_read(8'(8'h60 + 2 * i), rd);
            check(rd == 16'd0, "R1 preset", rd, 16'd0);
        end

        // R2: byte enables and unused bits
        reg_write(8'h66, 16'hFFFF, 2'b01);
        reg_read(8'h66, rd);
        check(rd == 16'h00FF, "R2 low byte", rd, 16'h00FF);
        reg_write(8'h66, 16'hFFFF, 2'b10);
        reg_read(8'h66, rd);
        check(rd == 16'hC7FF, "R2 high byte", rd, 16'hC7FF);

        // R10: unmapped and odd addresses
        reg_write(8'h61, 16'hFFFF, 2'b11);
        reg_write(8'h50, 16'hFFFF, 2'b11);
        reg_read(8'h60, rd);
        check(rd == 16'd0, "R10 preset0 untouched", rd, 16'd0);
        reg_read(8'h62, rd);
        check(rd == 16'd0, "R10 preset1 untouched", rd, 16'd0);
        reg_read(8'h61, rd);
        check(rd == 16'd0, "R10 odd read", rd, 16'd0);
        reg_read(8'h50, rd);
        check(rd == 16'd0, "R10 unmapped read", rd, 16'd0);

        // Load all presets and program software fields
        for (int i = 0; i < 8; i++) reg_write(8'(8'h60 + 2 * i), word_of(pval(i)), 2'b11);
        reg_read(8'h6A, rd);
        check(rd == word_of(pval(5)), "R2 full word", rd, word_of(pval(5)));
        {sw_drv_str, sw_clk_gen_sel, sw_clk_div} = SW_VAL;

        // Table walk: R3 R4 R5 R6 R7
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            set_mode(VEC[k]);
            ex = VEC[k][3:0];
            @(negedge clk);
            exp_v = (ex == 4'd8) ? SW_VAL : pval(int'(ex));
            if (ex == 4'd8) tag = VEC[k][5] ? "R7 reserved fallback" : "R3 software path";
            else if (ex == 4'd0) tag = "R6 init preset";
            else if (ex <= 4'd2) tag = "R4 3.3V decode";
            else tag = "R5 UHS decode";
            check(eff_now() == exp_v, tag, 16'(eff_now()), 16'(exp_v));
        end

        // R9: mode change latency
        @(negedge clk);
        set_mode({1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 4'd3});
        @(negedge clk);
        uhs_mode = 3'd1;
        #1 check(eff_now() == pval(3), "R9 before edge", 16'(eff_now()), 16'(pval(3)));
        @(negedge clk);
        check(eff_now() == pval(4), "R9 after edge", 16'(eff_now()), 16'(pval(4)));

        // R9: write to the selected preset
        @(negedge clk);
        reg_addr = 8'h68; reg_wdata = word_of(NEW_VAL); reg_be = 2'b11; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_be = '0;
        check(eff_now() == pval(4), "R9 write edge old", 16'(eff_now()), 16'(pval(4)));
        @(negedge clk);
        check(eff_now() == NEW_VAL, "R9 write visible", 16'(eff_now()), 16'(NEW_VAL));

        // R7 / R8: sticky flag
        reg_read(8'h70, rd);
        check(rd == 16'h0001, "R7 flag set", rd, 16'h0001);
        repeat (2) @(negedge clk);
        check(rsvd_flag == 1'b1, "R8 flag sticky", 16'(rsvd_flag), 16'd1);
        reg_write(8'h70, 16'h0000, 2'b01);
        reg_read(8'h70, rd);
        check(rd == 16'h0001, "R8 zero write keeps", rd, 16'h0001);
        reg_write(8'h70, 16'h0001, 2'b01);
        reg_read(8'h70, rd);
        check(rd == 16'h0000, "R8 clear", rd, 16'h0000);

        // R8: set and clear in the same cycle
        @(negedge clk);
        uhs_mode = 3'd6;
        reg_addr = 8'h70; reg_wdata = 16'h0001; reg_be = 2'b01; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_be = '0;
        #1 rd = reg_rdata;
        check(rd == 16'h0001, "R8 set beats clear", rd, 16'h0001);
        check(eff_now() == SW_VAL, "R7 uhs 6 fallback", 16'(eff_now()), 16'(SW_VAL));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule